// File: doc/BRIEF.md
# Rotate-Mask-Insert Shift Unit

This is a purely combinational 32-bit execution unit for the integer side of a RISC pipeline. It has two groups of operations. The first rotates a source word left and combines it with a generated contiguous bit mask. In one mode the rotated word is ANDed with the mask. In the other it is merged into the previous target value. The second group covers the word shifts: logical left, logical right, and arithmetic right by a register or an immediate amount. Each operation has a record variant that also raises one of three condition flags from the signed result. The arithmetic right shifts also produce a carry flag.

Every operation runs through one datapath: a logarithmic rotator, a mask generator and a merge stage. A small decoder turns each shift into a rotate amount, a mask window and a fill policy. Logical immediate shifts need no opcode of their own. Software gets them by picking the rotate amount and mask window on the rotate-then-AND path. Instruction decode, the register file, pipelining and exceptions belong to the surrounding core.

Top module: `rmsu_unit`

## Requirements
- R1: With op code 0 (rotate-AND, immediate amount), the result is the source rotated left by `amt_imm_i`, ANDed with the mask from R4.
- R2: With op code 1 (rotate-AND, register amount), the rotate amount is bits [4:0] of `amt_reg_i`, and the result is formed as in R1.
- R3: With op code 2 (rotate-insert, immediate amount), each result bit equals the rotated source bit where the mask bit is 1 and the `old_i` bit where the mask bit is 0.
- R4: Mask bits are numbered with index 0 as the most significant bit (vector bit 31). When begin <= end, the mask holds ones from `mb_i` through `me_i` inclusive. When begin > end, it holds ones from `mb_i` to 31 and from 0 to `me_i`. When begin equals end, exactly one bit is set.
- R5: With op code 3 (shift left), the amount is bits [5:0] of `amt_reg_i`. Amounts from 32 to 63 give zero.
- R6: With op code 4 (logical shift right), the amount is bits [5:0] of `amt_reg_i`, vacated bits are zero, and amounts from 32 to 63 give zero.
- R7: Op code 5 (arithmetic right by `amt_imm_i`) and op code 6 (arithmetic right by `amt_reg_i[5:0]`) fill vacated bits with copies of source bit 31. Register amounts from 32 to 63 give all copies of the sign.
- R8: For op codes 5 and 6, `ca_o` is 1 exactly when the source is negative and at least one 1 bit is shifted out.
- R9: For every op code other than 5 and 6, `ca_o` is 0.
- R10: When `rec_i` is 1, exactly one of `lt_o` (result negative as signed), `gt_o` (positive) and `eq_o` (zero) is 1. When `rec_i` is 0, all three are 0.
- R11: Op code 7 is reserved and gives a zero result with `ca_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 32 | Source operand to rotate or shift |
| old_i | input | 32 | Previous target value, merged in insert mode |
| amt_reg_i | input | 32 | Register operand supplying rotate or shift amount |
| amt_imm_i | input | 5 | Immediate rotate or shift amount |
| mb_i | input | 5 | Mask begin index (0 = MSB) |
| me_i | input | 5 | Mask end index (0 = MSB) |
| op_i | input | 3 | Operation select (codes as in requirements) |
| rec_i | input | 1 | Record form: update condition flags |
| res_o | output | 32 | Result word |
| ca_o | output | 1 | Carry from arithmetic right shifts |
| lt_o | output | 1 | Result negative (record form) |
| gt_o | output | 1 | Result positive (record form) |
| eq_o | output | 1 | Result zero (record form) |

## Verification
The bound checker re-evaluates a set of port-level rules every time the inputs settle:
- carry is only raised for the arithmetic shifts, and only with a negative source;
- at most one condition flag is raised, and only for record forms, with the negative flag matching the result's top bit;
- large logical and arithmetic shift amounts collapse to zero or to sign copies;
- the reserved code yields zero;
- a single-bit mask over all ones leaves exactly one bit.

Exact bit placement needs the bench's bit-by-bit reference model. This covers the wrapped mask windows, insert merging, carry from partly shifted-out words, and rotate amounts of 0 and 31. The model is driven with directed corners and seeded random operands.

// File: rtl/rmsu_pkg.sv
package rmsu_pkg;

    typedef enum logic [2:0] {
        OP_ROTAND_IMM = 3'd0,
        OP_ROTAND_REG = 3'd1,
        OP_ROTINS_IMM = 3'd2,
        OP_SHL_REG    = 3'd3,
        OP_SHR_REG    = 3'd4,
        OP_SRA_IMM    = 3'd5,
        OP_SRA_REG    = 3'd6,
        OP_RESERVED   = 3'd7
    } rmsu_op_e;

    // policy for result bits outside the mask window
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_OLD  = 2'd1,
        FILL_SIGN = 2'd2
    } rmsu_fill_e;

endpackage

// File: rtl/rmsu_rotator.sv
module rmsu_rotator #(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AW-1:0]    amt_i,
    output logic [WIDTH-1:0] data_o
);

    // one stage per amount bit; stage k rotates left by 2**k
    logic [WIDTH-1:0] stg [AW+1];

    assign stg[0] = data_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stg[k+1] = amt_i[k] ? {stg[k][WIDTH-1-SH:0], stg[k][WIDTH-1:WIDTH-SH]}
                                   : stg[k];
    end

    assign data_o = stg[AW];

endmodule

// File: rtl/rmsu_maskgen.sv
module rmsu_maskgen #(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [AW-1:0]    begin_i,
    input  logic [AW-1:0]    end_i,
    input  logic             none_i,
    output logic [WIDTH-1:0] mask_o
);

    logic wrap;
    assign wrap = begin_i > end_i;

    // index gi counts from the MSB; vector position is WIDTH-1-gi
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        logic at_or_after_begin;
        logic at_or_before_end;
        assign at_or_after_begin = AW'(gi) >= begin_i;
        assign at_or_before_end  = AW'(gi) <= end_i;
        assign mask_o[WIDTH-1-gi] = !none_i &&
            (wrap ? (at_or_after_begin || at_or_before_end)
                  : (at_or_after_begin && at_or_before_end));
    end

endmodule

// File: rtl/rmsu_decode.sv
module rmsu_decode
    import rmsu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  rmsu_op_e      op_i,
    input  logic [AW:0]   amt_reg_i,
    input  logic [AW-1:0] amt_imm_i,
    input  logic [AW-1:0] mb_i,
    input  logic [AW-1:0] me_i,
    output logic [AW-1:0] rot_amt_o,
    output logic [AW-1:0] win_begin_o,
    output logic [AW-1:0] win_end_o,
    output logic          win_none_o,
    output rmsu_fill_e    fill_o,
    output logic          carry_en_o
);

    localparam logic [AW-1:0] LAST_IDX = AW'(WIDTH - 1);

    logic [AW-1:0] reg_n;
    logic          reg_big;

    assign reg_n   = amt_reg_i[AW-1:0];
    assign reg_big = amt_reg_i[AW];

    always_comb begin
        rot_amt_o   = '0;
        win_begin_o = '0;
        win_end_o   = LAST_IDX;
        win_none_o  = 1'b0;
        fill_o      = FILL_ZERO;
        carry_en_o  = 1'b0;
        unique case (op_i)
            OP_ROTAND_IMM: begin
                rot_amt_o   = amt_imm_i;
                win_begin_o = mb_i;
                win_end_o   = me_i;
            end
            OP_ROTAND_REG: begin
                rot_amt_o   = reg_n;
                win_begin_o = mb_i;
                win_end_o   = me_i;
            end
            OP_ROTINS_IMM: begin
                rot_amt_o   = amt_imm_i;
                win_begin_o = mb_i;
                win_end_o   = me_i;
                fill_o      = FILL_OLD;
            end
            OP_SHL_REG: begin
                // keep the top WIDTH-n bits of a left rotation
                rot_amt_o   = reg_n;
                win_end_o   = ~reg_n;
                win_none_o  = reg_big;
            end
            OP_SHR_REG: begin
                // rotate left by WIDTH-n, keep MSB-indexed n..WIDTH-1
                rot_amt_o   = ~reg_n + AW'(1);
                win_begin_o = reg_n;
                win_none_o  = reg_big;
            end
            OP_SRA_IMM: begin
                rot_amt_o   = ~amt_imm_i + AW'(1);
                win_begin_o = amt_imm_i;
                fill_o      = FILL_SIGN;
                carry_en_o  = 1'b1;
            end
            OP_SRA_REG: begin
                rot_amt_o   = ~reg_n + AW'(1);
                win_begin_o = reg_n;
                win_none_o  = reg_big;
                fill_o      = FILL_SIGN;
                carry_en_o  = 1'b1;
            end
            OP_RESERVED: begin
                win_none_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rmsu_merge.sv
module rmsu_merge
    import rmsu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rot_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic [WIDTH-1:0] old_i,
    input  rmsu_fill_e       fill_i,
    input  logic             carry_en_i,
    input  logic             sign_i,
    input  logic             rec_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ca_o,
    output logic             lt_o,
    output logic             gt_o,
    output logic             eq_o
);

    logic [WIDTH-1:0] outside;
    logic             res_neg;
    logic             res_zero;

    always_comb begin
        unique case (fill_i)
            FILL_OLD:  outside = old_i & ~mask_i;
            FILL_SIGN: outside = {WIDTH{sign_i}} & ~mask_i;
            default:   outside = '0;
        endcase
    end

    assign res_o = (rot_i & mask_i) | outside;

    // bits outside the kept window of a right rotation are the ones shifted out
    assign ca_o = carry_en_i && sign_i && |(rot_i & ~mask_i);

    assign res_neg  = res_o[WIDTH-1];
    assign res_zero = res_o == '0;
    assign lt_o     = rec_i && res_neg;
    assign eq_o     = rec_i && res_zero;
    assign gt_o     = rec_i && !res_neg && !res_zero;

endmodule

// File: rtl/rmsu_unit.sv
module rmsu_unit
    import rmsu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] old_i,
    input  logic [WIDTH-1:0] amt_reg_i,
    input  logic [AW-1:0]    amt_imm_i,
    input  logic [AW-1:0]    mb_i,
    input  logic [AW-1:0]    me_i,
    input  logic [2:0]       op_i,
    input  logic             rec_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ca_o,
    output logic             lt_o,
    output logic             gt_o,
    output logic             eq_o
);

    logic [AW-1:0]    rot_amt;
    logic [AW-1:0]    win_begin;
    logic [AW-1:0]    win_end;
    logic             win_none;
    rmsu_fill_e       fill;
    logic             carry_en;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] mask;
    logic             unused_amt_hi;

    // only the low AW+1 bits of the register amount matter
    assign unused_amt_hi = ^amt_reg_i[WIDTH-1:AW+1];

    rmsu_decode #(.WIDTH(WIDTH)) u_decode (
        .op_i        (rmsu_op_e'(op_i)),
        .amt_reg_i   (amt_reg_i[AW:0]),
        .amt_imm_i   (amt_imm_i),
        .mb_i        (mb_i),
        .me_i        (me_i),
        .rot_amt_o   (rot_amt),
        .win_begin_o (win_begin),
        .win_end_o   (win_end),
        .win_none_o  (win_none),
        .fill_o      (fill),
        .carry_en_o  (carry_en)
    );

    rmsu_rotator #(.WIDTH(WIDTH)) u_rotator (
        .data_i (src_i),
        .amt_i  (rot_amt),
        .data_o (rotated)
    );

    rmsu_maskgen #(.WIDTH(WIDTH)) u_maskgen (
        .begin_i (win_begin),
        .end_i   (win_end),
        .none_i  (win_none),
        .mask_o  (mask)
    );

    rmsu_merge #(.WIDTH(WIDTH)) u_merge (
        .rot_i      (rotated),
        .mask_i     (mask),
        .old_i      (old_i),
        .fill_i     (fill),
        .carry_en_i (carry_en),
        .sign_i     (src_i[WIDTH-1]),
        .rec_i      (rec_i),
        .res_o      (res_o),
        .ca_o       (ca_o),
        .lt_o       (lt_o),
        .gt_o       (gt_o),
        .eq_o       (eq_o)
    );

endmodule

// File: rtl/rmsu_checker.sv
module rmsu_checker #(
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] src_i,
    input logic [AW:0]      amt_lo_i,
    input logic [AW-1:0]    amt_imm_i,
    input logic [AW-1:0]    mb_i,
    input logic [AW-1:0]    me_i,
    input logic [2:0]       op_i,
    input logic             rec_i,
    input logic [WIDTH-1:0] res_o,
    input logic             ca_o,
    input logic             lt_o,
    input logic             gt_o,
    input logic             eq_o
);

    always_comb begin
        // R9: carry only for codes 5 and 6
        assert_carry_sra_only_R9: assert (!(ca_o && op_i != 3'd5 && op_i != 3'd6));
        // R8: carry requires a negative source
        assert_carry_sign_R8: assert (!ca_o || src_i[WIDTH-1]);
        // R10: flag exclusivity and gating
        assert_flags_count_R10: assert ($countones({lt_o, gt_o, eq_o}) == (rec_i ? 1 : 0));
        assert_flag_neg_R10: assert (!lt_o || res_o[WIDTH-1]);
        // R5 / R6: large logical shifts clear the word
        assert_shl_big_R5: assert (!(op_i == 3'd3 && amt_lo_i[AW]) || res_o == '0);
        assert_shr_big_R6: assert (!(op_i == 3'd4 && amt_lo_i[AW]) || res_o == '0);
        // R7: large arithmetic shift yields sign copies
        assert_sra_big_R7: assert (!(op_i == 3'd6 && amt_lo_i[AW]) ||
                                   res_o == {WIDTH{src_i[WIDTH-1]}});
        // R11: reserved code
        assert_reserved_zero_R11: assert (op_i != 3'd7 || (res_o == '0 && !ca_o));
        // R1: full window with zero rotate passes the source through
        assert_rotand_identity_R1: assert (!(op_i == 3'd0 && amt_imm_i == '0 && mb_i == '0 &&
                                             me_i == AW'(WIDTH - 1)) || res_o == src_i);
        // R4: single-bit window over all ones leaves one bit
        assert_single_bit_mask_R4: assert (!(op_i == 3'd0 && mb_i == me_i && src_i == '1) ||
                                           $countones(res_o) == 1);
    end

endmodule

bind rmsu_unit rmsu_checker #(.WIDTH(WIDTH)) u_rmsu_checker (
    .src_i     (src_i),
    .amt_lo_i  (amt_reg_i[AW:0]),
    .amt_imm_i (amt_imm_i),
    .mb_i      (mb_i),
    .me_i      (me_i),
    .op_i      (op_i),
    .rec_i     (rec_i),
    .res_o     (res_o),
    .ca_o      (ca_o),
    .lt_o      (lt_o),
    .gt_o      (gt_o),
    .eq_o      (eq_o)
);

// File: tb/test_rmsu_unit.sv
`timescale 1ns/1ps
module test_rmsu_unit;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic [W-1:0]  src, old, areg, res;
    logic [4:0]    aimm, mb, me;
    logic [2:0]    op;
    logic          rec, ca, lt, gt, eq;
    int            n_cmp = 0;
    int            n_bad = 0;
    int            cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    rmsu_unit i_rmsu_unit (
        .src_i(src), .old_i(old), .amt_reg_i(areg), .amt_imm_i(aimm),
        .mb_i(mb), .me_i(me), .op_i(op), .rec_i(rec),
        .res_o(res), .ca_o(ca), .lt_o(lt), .gt_o(gt), .eq_o(eq)
    );

    function automatic logic [W-1:0] ref_mask(input int b, input int e);
        logic [W-1:0] m = '0;
        for (int i = 0; i < W; i++) begin
            if (b <= e) m[W-1-i] = (i >= b) && (i <= e);
            else        m[W-1-i] = (i >= b) || (i <= e);
        end
        return m;
    endfunction

    function automatic logic [W-1:0] ref_rotl(input logic [W-1:0] s, input int n);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[(i + n) % W] = s[i];
        return r;
    endfunction

    function automatic logic [W+3:0] ref_model(
        input logic [2:0] o, input logic [W-1:0] s, input logic [W-1:0] od,
        input logic [W-1:0] ar, input logic [4:0] ai, input logic [4:0] b,
        input logic [4:0] e, input logic rc);
        logic [W-1:0] r = '0;
        logic [W-1:0] m;
        logic c = 1'b0;
        int n;
        m = ref_mask(int'(b), int'(e));
        case (o)
            3'd0: r = ref_rotl(s, int'(ai)) & m;
            3'd1: r = ref_rotl(s, int'(ar[4:0])) & m;
            3'd2: begin
                r = ref_rotl(s, int'(ai));
                for (int i = 0; i < W; i++) if (!m[i]) r[i] = od[i];
            end
            3'd3: begin
                n = int'(ar[5:0]);
                for (int i = 0; i < W; i++) r[i] = (i >= n) ? s[i-n] : 1'b0;
            end
            3'd4: begin
                n = int'(ar[5:0]);
                for (int i = 0; i < W; i++) r[i] = (i + n < W) ? s[i+n] : 1'b0;
            end
            3'd5, 3'd6: begin
                n = (o == 3'd5) ? int'(ai) : int'(ar[5:0]);
                for (int i = 0; i < W; i++) r[i] = (i + n < W) ? s[i+n] : s[W-1];
                for (int j = 0; j < W; j++) if (j < n && s[j] && s[W-1]) c = 1'b1;
            end
            default: r = '0;
        endcase
        return {r, c, rc && r[W-1], rc && !r[W-1] && r != '0, rc && r == '0};
    endfunction

    task automatic apply(input logic [2:0] o, input logic [W-1:0] s, input logic [W-1:0] od,
                         input logic [W-1:0] ar, input logic [4:0] ai, input logic [4:0] b,
                         input logic [4:0] e, input logic rc, input string tag);
        logic [W+3:0] exp_v;
        @(negedge clk);
        op = o; src = s; old = od; areg = ar; aimm = ai; mb = b; me = e; rec = rc;
        #5;
        exp_v = ref_model(o, s, od, ar, ai, b, e, rc);
        n_cmp++;
        if ({res, ca, lt, gt, eq} !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d: got res=%h ca=%b lt/gt/eq=%b%b%b, expected res=%h ca=%b lt/gt/eq=%b",
                     tag, o, res, ca, lt, gt, eq, exp_v[W+3:4], exp_v[3], exp_v[2:0]);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7/R8";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] ro;
        logic [W-1:0] rar;
        int unsigned seed_dummy;
        op = '0; src = '0; old = '0; areg = '0; aimm = '0; mb = '0; me = '0; rec = 1'b0;
        seed_dummy = $urandom(32'd20240611);
        // idle state with zero inputs, record form: zero flag
        apply(3'd0, '0, '0, '0, 5'd0, 5'd0, 5'd0, 1'b1, "R10 idle");
        // rotate-AND corners
        apply(3'd0, 32'h8000_0001, '0, '0, 5'd0, 5'd0, 5'd31, 1'b0, "R1 zero rotate");
        apply(3'd0, 32'hFFFF_FFFF, '0, '0, 5'd7, 5'd9, 5'd9, 1'b0, "R4 begin equals end");
        apply(3'd0, 32'hFFFF_FFFF, '0, '0, 5'd0, 5'd28, 5'd3, 1'b0, "R4 wrap mask");
        apply(3'd0, 32'h1234_5678, '0, '0, 5'd31, 5'd4, 5'd27, 1'b1, "R1 rotate 31");
        apply(3'd0, 32'h1234_5678, '0, '0, 5'd4, 5'd0, 5'd27, 1'b0, "R1 immediate shift left 4");
        apply(3'd1, 32'hDEAD_BEEF, '0, 32'hFFFF_FFE8, 5'd0, 5'd16, 5'd5, 1'b1, "R2 register amount wraps");
        apply(3'd2, 32'h00FF_00FF, 32'hA5A5_A5A5, '0, 5'd8, 5'd30, 5'd1, 1'b0, "R3 insert wrap");
        apply(3'd2, 32'hFFFF_FFFF, 32'h0000_0000, '0, 5'd0, 5'd12, 5'd12, 1'b1, "R3 insert single");
        // shift corners 31, 32, 63, 0
        apply(3'd3, 32'h0000_0003, '0, 32'd31, 5'd0, 5'd0, 5'd0, 1'b1, "R5 shift 31");
        apply(3'd3, 32'hFFFF_FFFF, '0, 32'd32, 5'd0, 5'd0, 5'd0, 1'b1, "R5 shift 32");
        apply(3'd3, 32'hFFFF_FFFF, '0, 32'hFFFF_FF3F, 5'd0, 5'd0, 5'd0, 1'b0, "R5 shift 63 high bits ignored");
        apply(3'd4, 32'h8000_0000, '0, 32'd31, 5'd0, 5'd0, 5'd0, 1'b1, "R6 shift 31");
        apply(3'd4, 32'hFFFF_FFFF, '0, 32'd63, 5'd0, 5'd0, 5'd0, 1'b0, "R6 shift 63");
        apply(3'd4, 32'h8765_4321, '0, 32'd0, 5'd0, 5'd0, 5'd0, 1'b1, "R6 shift 0");
        apply(3'd5, 32'h8000_0001, '0, '0, 5'd1, 5'd0, 5'd0, 1'b1, "R8 carry negative");
        apply(3'd5, 32'h0000_0001, '0, '0, 5'd1, 5'd0, 5'd0, 1'b1, "R8 no carry positive");
        apply(3'd5, 32'h8000_0000, '0, '0, 5'd31, 5'd0, 5'd0, 1'b1, "R7 immediate 31");
        apply(3'd6, 32'h8000_0000, '0, 32'd31, 5'd0, 5'd0, 5'd0, 1'b0, "R8 exact no carry");
        apply(3'd6, 32'h9000_0000, '0, 32'd32, 5'd0, 5'd0, 5'd0, 1'b1, "R7 shift 32");
        apply(3'd6, 32'h7FFF_FFFF, '0, 32'd63, 5'd0, 5'd0, 5'd0, 1'b1, "R7 shift 63 positive");
        apply(3'd6, 32'hC000_0000, '0, 32'd0, 5'd0, 5'd0, 5'd0, 1'b0, "R8 shift 0 no carry");
        apply(3'd1, 32'hFFFF_FFFF, '0, 32'd1, 5'd0, 5'd0, 5'd31, 1'b0, "R9 no carry rotate");
        apply(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 5'd5, 5'd1, 5'd2, 1'b1, "R11 reserved");
        // seeded random mix with biased amounts
        for (int it = 0; it < 3000; it++) begin
            ro  = 3'($urandom % 8);
            rar = $urandom;
            if (($urandom % 4) == 0) begin
                case ($urandom % 4)
                    0: rar[5:0] = 6'd0;
                    1: rar[5:0] = 6'd31;
                    2: rar[5:0] = 6'd32;
                    default: rar[5:0] = 6'd63;
                endcase
            end
            apply(ro, $urandom, $urandom, rar, 5'($urandom), 5'($urandom), 5'($urandom),
                  1'($urandom), tag_of(ro));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule